// File: doc/BRIEF.md
# Addend-Tuned Precision Time Counter

This block keeps a free-running 64-bit time count for an IEEE 1588 time-stamping unit. One count step stands for 32 ns. The count does not advance every clock. A 32-bit fractional accumulator adds a programmable addend on each cycle, and the count moves forward by one only in the cycles where that sum carries past 2^32. Software corrects drift by trimming the addend up or down. It never changes the size of the count step. With a 50 MHz clock and the reset addend the count runs at 31.25 M steps per second.

Software reaches the block through a small 32-bit register port with single-cycle reads and writes:

- The 64-bit time is always accessed low word first, then high word.
  - Reading the low word freezes the matching high word for the read that follows.
  - Writing the high word loads both halves at once and restarts the fractional phase.
- The low word rolls over at a programmable limit. That limit can only be changed while a separate enable register is set.
- A 64-bit target time raises a sticky pending flag when the count equals it. That flag can drive an interrupt line.
- A self-held reset bit in the control register returns all time, event and configuration state to defaults for as long as it stays set.

The current time is also driven on `time_now` for the neighbouring timestamp capture logic.

Top module: `prec_time_counter`

## Requirements
- R1: After `rst_n` deasserts, the registers read as follows:
  - control (word 0) reads 0;
  - event (word 1) reads 0;
  - addend (word 2) reads 0xA0000000;
  - low-word limit enable (word 5) reads 0;
  - low-word limit (word 6) reads 0xFFFFFFFF;
  - `time_now` is 0.
- R2: In each cycle the accumulator becomes (accumulator + addend) mod 2^32. `time_now` advances by exactly one in the cycles where that sum is 2^32 or more, and stays unchanged otherwise. An addend of 0 freezes the time.
- R3: When a step occurs and the low word is at or above the limit, the low word becomes 0 and the high word increments. Otherwise the whole 64-bit value increments by one.
- R4: A write to the limit register (word 6) takes effect only while bit 0 of the limit enable register (word 5) is 1. When the enable is 0, the write is ignored and the old limit reads back.
- R5: A read of the time low word (word 3) returns the current low word and captures the current high word. A later read of the time high word (word 4) returns that captured value, even if the count has carried since.
- R6: A write to word 3 only stages the low half and leaves `time_now` unchanged. A write to word 4 loads {written high, staged low} into the time in that cycle and clears the accumulator. A load takes priority over a step in the same cycle.
- R7: Event bit 1 (word 1) becomes 1 in the cycle after `time_now` equals the target. It stays 1 until software writes 1 to event bit 1. A match in the same cycle as that write wins over the clear.
  - Target bits 31:0 are written to word 7, where they are staged.
  - Target bits 63:32 are written to word 8, which commits the full target.
  - The target resets to all ones.
- R8: `target_irq` equals event bit 1 ANDed with control bit 1.
- R9: While control bit 0 is 1:
  - time, accumulator, event flag, shadow and staging registers are held at their reset values;
  - addend, limit, limit enable and target are held at their reset values;
  - writes to all words other than control are ignored.
  
  Counting resumes once software clears control bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| rd_en | input | 1 | Register read strobe; a read of word 3 updates the high-word shadow |
| addr | input | 4 | Register word index |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| time_now | output | 64 | Current time count (32 ns steps) |
| target_irq | output | 1 | Target-reached interrupt request |

## Verification
The hardest case to reach from the ports is a split read in which the low word is near its limit and the count carries between the low-word read and the high-word read. The high word returned must then be the captured value and not the live one. The bench loads a time just below the carry point and sets the addend to its maximum so that a step happens on almost every cycle. It reads the low word, waits past the carry, and then reads the high word. Reduced wrap limits and target matches are reached the same way: the bench loads the time just before the point of interest rather than waiting for it.

// File: rtl/ptc_pkg.sv
package ptc_pkg;
  localparam int unsigned REG_W  = 32;
  localparam int unsigned TIME_W = 2 * REG_W;
  localparam int unsigned ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL     = 4'd0,
    A_EVENT    = 4'd1,
    A_ADDEND   = 4'd2,
    A_TIME_LO  = 4'd3,
    A_TIME_HI  = 4'd4,
    A_LOMAX_EN = 4'd5,
    A_LOMAX    = 4'd6,
    A_TGT_LO   = 4'd7,
    A_TGT_HI   = 4'd8
  } reg_addr_e;

  localparam int CTRL_SRST_BIT = 0;
  localparam int CTRL_TIE_BIT  = 1;
  localparam int EV_TGT_BIT    = 1;

  localparam logic [REG_W-1:0]  ONE_W = 1;
  localparam logic [TIME_W-1:0] ONE_T = 1;

  // fractional step: carry bit on top of the new accumulator value
  function automatic logic [REG_W:0] frac_sum(input logic [REG_W-1:0] acc,
                                              input logic [REG_W-1:0] add);
    return {1'b0, acc} + {1'b0, add};
  endfunction

  // one time step honouring the programmable low-word limit
  function automatic logic [TIME_W-1:0] time_step(input logic [TIME_W-1:0] t,
                                                  input logic [REG_W-1:0]  lim);
    if (t[REG_W-1:0] >= lim)
      return {t[TIME_W-1:REG_W] + ONE_W, {REG_W{1'b0}}};
    return t + ONE_T;
  endfunction
endpackage

// File: rtl/ptc_regs.sv
module ptc_regs
  import ptc_pkg::*;
#(
  parameter logic [REG_W-1:0]  ADDEND_RST = 32'hA000_0000,
  parameter logic [REG_W-1:0]  LOMAX_RST  = 32'hFFFF_FFFF,
  parameter logic [TIME_W-1:0] TARGET_RST = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [1:0]        ctrl_q,
  output logic [REG_W-1:0]  addend_q,
  output logic              lomax_en_q,
  output logic [REG_W-1:0]  lomax_q,
  output logic [TIME_W-1:0] target_q
);
  logic             soft_rst;
  logic [REG_W-1:0] tgt_stage_q;

  assign soft_rst = ctrl_q[CTRL_SRST_BIT];

  // control register is the only one left alone by the soft reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ctrl_q <= '0;
    else if (wr_en && addr == A_CTRL)
      ctrl_q <= wdata[1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addend_q    <= ADDEND_RST;
      lomax_en_q  <= 1'b0;
      lomax_q     <= LOMAX_RST;
      target_q    <= TARGET_RST;
      tgt_stage_q <= '0;
    end else if (soft_rst) begin
      addend_q    <= ADDEND_RST;
      lomax_en_q  <= 1'b0;
      lomax_q     <= LOMAX_RST;
      target_q    <= TARGET_RST;
      tgt_stage_q <= '0;
    end else if (wr_en) begin
      case (addr)
        A_ADDEND:   addend_q   <= wdata;
        A_LOMAX_EN: lomax_en_q <= wdata[0];
        A_LOMAX:    if (lomax_en_q) lomax_q <= wdata;
        A_TGT_LO:   tgt_stage_q <= wdata;
        A_TGT_HI:   target_q <= {wdata, tgt_stage_q};
        default: ;
      endcase
    end
  end

  // R4: limit is frozen unless its enable is set
  p_lomax_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!soft_rst && !lomax_en_q) |=> $stable(lomax_q));

  // R9: configuration returns to defaults under soft reset
  p_soft_cfg_r9: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (addend_q == ADDEND_RST && lomax_q == LOMAX_RST && !lomax_en_q));
endmodule

// File: rtl/ptc_frac_accum.sv
module ptc_frac_accum
  import ptc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             clr,
  input  logic [REG_W-1:0] addend,
  output logic             tick,
  output logic [REG_W-1:0] acc_q
);
  logic [REG_W:0] sum;

  assign sum  = frac_sum(acc_q, addend);
  assign tick = sum[REG_W] & ~soft_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      acc_q <= '0;
    else if (soft_rst || clr)
      acc_q <= '0;
    else
      acc_q <= sum[REG_W-1:0];
  end

  // R6: a time load restarts the fractional phase
  p_load_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> acc_q == '0);

  // R2: without a load the accumulator moves by the addend modulo 2^32
  p_acc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!soft_rst && !clr) |=> acc_q == $past(acc_q) + $past(addend));
endmodule

// File: rtl/ptc_time_core.sv
module ptc_time_core
  import ptc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              tick,
  input  logic [REG_W-1:0]  lomax,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [TIME_W-1:0] time_q,
  output logic [REG_W-1:0]  shadow_hi_q,
  output logic              commit
);
  logic             lo_wr;
  logic             lo_rd;
  logic [REG_W-1:0] stage_lo_q;

  assign lo_wr  = wr_en && addr == A_TIME_LO && !soft_rst;
  assign lo_rd  = rd_en && addr == A_TIME_LO && !soft_rst;
  assign commit = wr_en && addr == A_TIME_HI && !soft_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      time_q      <= '0;
      stage_lo_q  <= '0;
      shadow_hi_q <= '0;
    end else if (soft_rst) begin
      time_q      <= '0;
      stage_lo_q  <= '0;
      shadow_hi_q <= '0;
    end else begin
      if (lo_wr) stage_lo_q  <= wdata;
      if (lo_rd) shadow_hi_q <= time_q[TIME_W-1:REG_W];
      if (commit)
        time_q <= {wdata, stage_lo_q};
      else if (tick)
        time_q <= time_step(time_q, lomax);
    end
  end

  // R2: no carry, no load -> time holds
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!soft_rst && !commit && !tick) |=> $stable(time_q));

  // R3: step at or above the limit wraps the low word
  p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!soft_rst && !commit && tick && time_q[REG_W-1:0] >= lomax)
      |=> time_q[REG_W-1:0] == '0);

  // R5: low read captures the live high word
  p_shadow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lo_rd |=> shadow_hi_q == $past(time_q[TIME_W-1:REG_W]));

  // R6: high write loads the written high word
  p_commit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> time_q[TIME_W-1:REG_W] == $past(wdata));

  // R9: soft reset zeroes the time
  p_soft_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> time_q == '0);
endmodule

// File: rtl/ptc_target_cmp.sv
module ptc_target_cmp
  import ptc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic [TIME_W-1:0] time_now,
  input  logic [TIME_W-1:0] target,
  input  logic              ev_clr,
  output logic              pending_q
);
  logic hit;

  assign hit = (time_now == target);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pending_q <= 1'b0;
    else if (soft_rst)
      pending_q <= 1'b0;
    else if (hit)
      pending_q <= 1'b1;
    else if (ev_clr)
      pending_q <= 1'b0;
  end

  // R7: a match always leaves the flag set
  p_hit_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !soft_rst) |=> pending_q);

  // R7: a clear without a match drops the flag
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_clr && !hit && !soft_rst) |=> !pending_q);
endmodule

// File: rtl/prec_time_counter.sv
module prec_time_counter
  import ptc_pkg::*;
#(
  parameter logic [REG_W-1:0]  ADDEND_RST = 32'hA000_0000,
  parameter logic [REG_W-1:0]  LOMAX_RST  = 32'hFFFF_FFFF,
  parameter logic [TIME_W-1:0] TARGET_RST = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  output logic [TIME_W-1:0] time_now,
  output logic              target_irq
);
  logic [1:0]        ctrl_q;
  logic [REG_W-1:0]  addend_q;
  logic              lomax_en_q;
  logic [REG_W-1:0]  lomax_q;
  logic [TIME_W-1:0] target_q;
  logic              soft_rst;
  logic              tick;
  logic              commit;
  logic [REG_W-1:0]  acc_q;
  logic [REG_W-1:0]  shadow_hi_q;
  logic              pending_q;
  logic              ev_clr;

  assign soft_rst = ctrl_q[CTRL_SRST_BIT];
  assign ev_clr   = wr_en && addr == A_EVENT && wdata[EV_TGT_BIT];

  ptc_regs #(
    .ADDEND_RST(ADDEND_RST),
    .LOMAX_RST (LOMAX_RST),
    .TARGET_RST(TARGET_RST)
  ) regs_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata     (wdata),
    .ctrl_q    (ctrl_q),
    .addend_q  (addend_q),
    .lomax_en_q(lomax_en_q),
    .lomax_q   (lomax_q),
    .target_q  (target_q)
  );

  ptc_frac_accum accum_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .soft_rst(soft_rst),
    .clr     (commit),
    .addend  (addend_q),
    .tick    (tick),
    .acc_q   (acc_q)
  );

  ptc_time_core core_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_rst   (soft_rst),
    .tick       (tick),
    .lomax      (lomax_q),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .addr       (addr),
    .wdata      (wdata),
    .time_q     (time_now),
    .shadow_hi_q(shadow_hi_q),
    .commit     (commit)
  );

  ptc_target_cmp cmp_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_rst (soft_rst),
    .time_now (time_now),
    .target   (target_q),
    .ev_clr   (ev_clr),
    .pending_q(pending_q)
  );

  assign target_irq = pending_q & ctrl_q[CTRL_TIE_BIT];

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL:     rdata[1:0] = ctrl_q;
      A_EVENT:    rdata[EV_TGT_BIT] = pending_q;
      A_ADDEND:   rdata = addend_q;
      A_TIME_LO:  rdata = time_now[REG_W-1:0];
      A_TIME_HI:  rdata = shadow_hi_q;
      A_LOMAX_EN: rdata[0] = lomax_en_q;
      A_LOMAX:    rdata = lomax_q;
      A_TGT_LO:   rdata = target_q[REG_W-1:0];
      A_TGT_HI:   rdata = target_q[TIME_W-1:REG_W];
      default: ;
    endcase
  end

  // R8: the request line never rises while the enable bit is clear
  p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[CTRL_TIE_BIT] |-> !target_irq);
endmodule

// File: tb/prec_time_counter_tb.sv
module prec_time_counter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [63:0] time_now;
  logic        target_irq;

  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 1'b0;
  string phase_req = "R1";

  always #4 clk = ~clk;

  prec_time_counter dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .time_now(time_now), .target_irq(target_irq)
  );

  // behavioural reference model
  logic [63:0] m_time, m_target;
  logic [31:0] m_acc, m_addend, m_lomax, m_lo_stage, m_tg_stage, m_shadow;
  logic        m_en, m_pend;
  logic [1:0]  m_ctrl;

  task automatic m_defaults();
    m_time = 0; m_target = '1; m_acc = 0; m_addend = 32'hA000_0000;
    m_lomax = 32'hFFFF_FFFF; m_lo_stage = 0; m_tg_stage = 0; m_shadow = 0;
    m_en = 0; m_pend = 0;
  endtask

  always @(posedge clk) begin : model
    logic [32:0] s;
    logic [63:0] t_next;
    logic        p_next;
    if (!rst_n) begin
      m_defaults();
      m_ctrl = 0;
    end else if (m_ctrl[0]) begin
      m_defaults();
      if (wr_en && addr == 0) m_ctrl = wdata[1:0];
    end else begin
      s = {1'b0, m_acc} + {1'b0, m_addend};
      t_next = m_time;
      if (s[32]) t_next = (m_time[31:0] >= m_lomax) ? {m_time[63:32] + 32'd1, 32'd0}
                                                    : m_time + 64'd1;
      p_next = m_pend;
      if (wr_en && addr == 1 && wdata[1]) p_next = 0;
      if (m_time == m_target) p_next = 1;
      m_acc = s[31:0];
      if (rd_en && addr == 3) m_shadow = m_time[63:32];
      if (wr_en) begin
        case (addr)
          0: m_ctrl = wdata[1:0];
          2: m_addend = wdata;
          3: m_lo_stage = wdata;
          4: begin t_next = {wdata, m_lo_stage}; m_acc = 0; end
          5: m_en = wdata[0];
          6: if (m_en) m_lomax = wdata;
          7: m_tg_stage = wdata;
          8: m_target = {wdata, m_tg_stage};
          default: ;
        endcase
      end
      m_time = t_next;
      m_pend = p_next;
    end
  end

  function automatic logic [31:0] exp_rd(input logic [3:0] a);
    case (a)
      0: return {30'd0, m_ctrl};
      1: return {30'd0, m_pend, 1'b0};
      2: return m_addend;
      3: return m_time[31:0];
      4: return m_shadow;
      5: return {31'd0, m_en};
      6: return m_lomax;
      7: return m_target[31:0];
      8: return m_target[63:32];
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    #2;
    if (rst_n && !done) begin
      check(phase_req, "time_now", time_now, m_time);
      check("R8", "target_irq", {63'd0, target_irq}, {63'd0, m_pend & m_ctrl[1]});
      if (rd_en) check(phase_req, "rdata", {32'd0, rdata}, {32'd0, exp_rd(addr)});
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; rd_en = 0; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1; wr_en = 0; addr = a;
    #2 d = rdata;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual=expired expected=finished");
    finish_run();
  end

  initial begin : stim
    logic [31:0] d;
    repeat (4) @(negedge clk);
    rst_n = 1;
    // R1 reset values
    phase_req = "R1";
    #2 check("R1", "time after reset", time_now, 64'd0);
    rd(0, d); check("R1", "ctrl", {32'd0, d}, 64'd0);
    rd(1, d); check("R1", "event", {32'd0, d}, 64'd0);
    rd(2, d); check("R1", "addend", {32'd0, d}, 64'hA000_0000);
    rd(5, d); check("R1", "limit enable", {32'd0, d}, 64'd0);
    rd(6, d); check("R1", "limit", {32'd0, d}, 64'hFFFF_FFFF);

    // R2 accumulator rates
    phase_req = "R2";
    idle(40);
    wr(2, 32'h8000_0000); wr(3, 0); wr(4, 0);
    idle(40);
    wr(2, 32'hFFFF_FFFF); idle(20);
    wr(2, 0); idle(10);
    check("R2", "frozen with zero addend", time_now, m_time);
    wr(2, 32'h1234_5678); idle(60);

    // R4 limit gating, R3 wrap
    phase_req = "R4";
    wr(6, 9); rd(6, d); check("R4", "limit write ignored", {32'd0, d}, 64'hFFFF_FFFF);
    wr(5, 1); wr(6, 9); wr(5, 0); wr(6, 5);
    rd(6, d); check("R4", "limit gated value", {32'd0, d}, 64'd9);
    phase_req = "R3";
    wr(2, 32'h8000_0000); wr(3, 0); wr(4, 32'h0000_0002);
    idle(50);
    check("R3", "low word within limit", {63'd0, time_now[31:0] <= 32'd9}, 64'd1);
    check("R3", "high word advanced", {63'd0, time_now[63:32] > 32'd2}, 64'd1);
    wr(5, 1); wr(6, 32'hFFFF_FFFF); wr(5, 0);

    // R5 split read across a carry
    phase_req = "R5";
    wr(2, 32'hFFFF_FFFF); wr(3, 32'hFFFF_FFF0); wr(4, 7);
    rd(3, d);
    idle(30);
    check("R5", "live high moved", {32'd0, time_now[63:32]}, 64'd8);
    rd(4, d); check("R5", "shadow high", {32'd0, d}, 64'd7);

    // R6 staged low, committed high
    phase_req = "R6";
    wr(2, 0); wr(3, 32'hDEAD_0000);
    check("R6", "low write only staged", time_now, m_time);
    wr(4, 32'h0000_0ABC);
    check("R6", "committed time", time_now, 64'h0000_0ABC_DEAD_0000);

    // R7/R8 target
    phase_req = "R7";
    wr(2, 32'h8000_0000); wr(3, 100); wr(4, 0);
    wr(7, 130); wr(8, 0);
    wr(0, 2);
    idle(80);
    check("R8", "irq raised", {63'd0, target_irq}, 64'd1);
    rd(1, d); check("R7", "event pending", {32'd0, d}, 64'd2);
    wr(1, 2);
    rd(1, d); check("R7", "event cleared", {32'd0, d}, 64'd0);
    check("R8", "irq dropped", {63'd0, target_irq}, 64'd0);

    // R9 soft reset
    phase_req = "R9";
    wr(0, 1); wr(2, 5);
    rd(2, d); check("R9", "addend write ignored", {32'd0, d}, 64'hA000_0000);
    idle(5);
    check("R9", "time held at zero", time_now, 64'd0);
    wr(0, 0); idle(20);
    check("R9", "counting resumed", {63'd0, time_now != 64'd0}, 64'd1);

    // mixed traffic checked against the model every cycle
    phase_req = "R2";
    for (int i = 0; i < 1500; i++) begin
      int op;
      logic [3:0] a;
      logic [31:0] v;
      op = int'($urandom_range(0, 3));
      a  = 4'($urandom_range(0, 9));
      v  = $urandom;
      if (a == 0) v = v & ((($urandom & 7) == 0) ? 32'h3 : 32'h2);
      if (a == 6 && v[0]) v = v & 32'h0000_00FF;
      case (op)
        0: wr(a, v);
        1: rd(a, d);
        default: idle(1);
      endcase
    end
    wr(0, 0);
    idle(5);
    finish_run();
  end
endmodule